// File: doc/BRIEF.md
# Two-Wire Serial Shifter with Readback Check

This block is an 8-bit master shift unit for a two-wire bus made of a clock line and one shared open-drain data line. Software writes a byte into the shift register through a small register port. If the interface is already enabled and the serial clock is idle, that write starts a transfer. The block then generates the serial clock from the system clock and shifts the byte out MSB first. A 0 bit pulls the data line low and a 1 bit releases it. After eight bits the clock stops high and a sticky completion flag is raised.

On every bit the level actually present on the wired line is shifted back into the same register. After a transfer the register therefore holds what the bus carried, and not what was intended. A receive is done by loading 0xFF, so the block never pulls the line and the remote device drives it. To detect a transmit error, software loads the same byte into a compare register. When the transfer has finished, a match flag reads 1 when the two registers are equal and 0 when a collision or other error changed a bit. The register port is plain control access with no stream handshake. Every write is accepted in the cycle it is presented, and there is no back-pressure.

Top module: `twowire_shifter`

## Requirements
- R1: After reset the clock output is high, `sda_oe` is 0, `irq` is 0, the shift and compare registers read 0x00, and the status register (address 2) reads 0x04 (bit0 enable=0, bit1 interrupt=0, bit2 match=1).
- R2: A write to the shift register (address 0) starts a transfer only if the enable bit (control bit0, address 2) was already 1 before that write. Setting enable after the write produces no clock edge and no interrupt.
- R3: A transfer produces exactly 8 rising clock edges spaced 2*HALF_DIV system clocks apart. The clock then stays high and `irq` is set.
- R4: `sda_oe`=1 means pull the line low. It is 1 only while a 0 bit is being sent. Bits go out MSB first, each changing after a falling clock edge and stable through the following rising edge.
- R5: The line is sampled on each rising clock edge through a two-stage synchroniser. After a transfer the shift register equals the bitwise AND of the sent byte and the byte driven by the remote device.
- R6: With 0xFF loaded, `sda_oe` stays 0 for the whole transfer and the shift register ends holding the remote byte.
- R7: While no transfer is active, status bit2 is 1 exactly when the shift register equals the compare register (address 1).
- R8: A write to the shift register during a transfer is ignored. The transfer still completes with 8 edges, and its result is unchanged.
- R9: `irq` stays set until a control write with bit1=0. A control write with bit1=1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 shift, 1 compare, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 shift, 1 compare, 2 status |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Sticky transfer-complete flag |
| scl_out | output | 1 | Serial clock, idles high |
| sda_oe | output | 1 | Data line pull-low enable (open drain) |
| sda_in | input | 1 | Observed data line level |

## Verification
A transmit-only byte with the remote device released (0xA5) shows that the clock count, bit spacing and MSB-first ordering are right. It also shows that readback returns the sent byte with a match. A colliding pattern (0xF0 against a remote 0x3C) tells true wired-line sampling apart from a design that keeps its own transmitted copy: the result must be 0x30 and the match flag must drop. A 0xFF receive of 0x96 shows that the block never pulls the line while listening. Writes made before enable and during a transfer show that the start rules and the ignore rule hold, and control writes with and without bit1 show that the interrupt flag stays set until cleared.

// File: rtl/twsh_pkg.sv
package twsh_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ADDR_SHIFT = 2'd0,
    ADDR_CMP   = 2'd1,
    ADDR_CTRL  = 2'd2
  } reg_addr_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQ_BIT   = 1;
  localparam int STAT_MATCH_BIT = 2;
endpackage

// File: rtl/twsh_sync.sv
module twsh_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twsh_clkgen.sv
module twsh_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic scl,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == LAST);
  assign fall_tick = wrap && scl;
  assign rise_tick = wrap && !scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      scl <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      scl <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      scl <= ~scl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twsh_shifter.sv
module twsh_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          start,
  input  logic          fall_tick,
  input  logic          rise_tick,
  input  logic          line_bit,
  output logic          busy,
  output logic          done,
  output logic          oe,
  output logic [DW-1:0] sreg
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [BW-1:0] bit_cnt;

  assign done = busy && rise_tick && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      busy    <= 1'b0;
      oe      <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (load) sreg <= load_data;
      if (start) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
      end
      if (busy && fall_tick) oe <= ~sreg[DW-1];
      if (busy && rise_tick) begin
        sreg    <= {sreg[DW-2:0], line_bit};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          busy <= 1'b0;
          oe   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/twowire_shifter.sv
module twowire_shifter
  import twsh_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          scl_out,
  output logic          sda_oe,
  input  logic          sda_in
);
  logic          busy, done, fall_tick, rise_tick, line_bit;
  logic          en_q, irq_q, match_hold, match;
  logic [DW-1:0] sreg, cmp_q;
  logic          wr_shift, wr_cmp, wr_ctrl, load, start;

  assign wr_shift = wr_en && (wr_addr == ADDR_SHIFT);
  assign wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign load     = wr_shift && !busy;
  assign start    = load && en_q && scl_out;

  twsh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(line_bit)
  );

  twsh_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .scl(scl_out), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  twsh_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .start(start), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .line_bit(line_bit), .busy(busy), .done(done), .oe(sda_oe), .sreg(sreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      irq_q      <= 1'b0;
      cmp_q      <= '0;
      match_hold <= 1'b1;
    end else begin
      if (wr_cmp)  cmp_q <= wr_data;
      if (wr_ctrl) en_q  <= wr_data[CTRL_EN_BIT];
      if (done)
        irq_q <= 1'b1;
      else if (wr_ctrl && !wr_data[CTRL_IRQ_BIT])
        irq_q <= 1'b0;
      if (!busy) match_hold <= (sreg == cmp_q);
    end
  end

  assign match = busy ? match_hold : (sreg == cmp_q);
  assign irq   = irq_q;

  always_comb begin
    unique case (rd_addr)
      ADDR_SHIFT: rd_data = sreg;
      ADDR_CMP:   rd_data = cmp_q;
      ADDR_CTRL: begin
        rd_data = '0;
        rd_data[CTRL_EN_BIT]    = en_q;
        rd_data[CTRL_IRQ_BIT]   = irq_q;
        rd_data[STAT_MATCH_BIT] = match;
      end
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/twsh_checker.sv
module twsh_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic en_q,
  input logic scl_out,
  input logic sda_oe,
  input logic irq,
  input logic ctrl_clr
);
  AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_out); // R3

  AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R3

  AST_IDLE_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe); // R4

  AST_DRIVE_CHANGES_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sda_oe)) |-> !scl_out); // R4

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en_q) |=> !busy); // R2

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_clr) |=> irq); // R9
endmodule

bind twowire_shifter twsh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .en_q(en_q), .scl_out(scl_out),
  .sda_oe(sda_oe), .irq(irq),
  .ctrl_clr(wr_en && (wr_addr == 2'd2) && !wr_data[1])
);

// File: tb/twowire_shifter_test.sv
module twowire_shifter_test;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq, scl_out, sda_oe, sda_line;

  logic       remote_low = 1'b0;
  logic [7:0] remote_byte = 8'hFF;
  int         remote_idx = 8;
  logic [7:0] obs_line = 8'h00;
  int         rises = 0;
  int         oe_cycles = 0;
  time        first_rise = 0, last_rise = 0;

  int errors = 0, checks = 0;

  assign sda_line = !sda_oe && !remote_low;

  twowire_shifter #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .scl_out(scl_out), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always #5 clk = ~clk;

  always @(negedge scl_out) begin
    if (remote_idx < 8) begin
      remote_low <= ~remote_byte[7 - remote_idx];
      remote_idx <= remote_idx + 1;
    end
  end

  always @(posedge scl_out) begin
    obs_line <= {obs_line[6:0], sda_line};
    if (rises == 0) first_rise = $time;
    last_rise = $time;
    rises <= rises + 1;
    if (remote_idx >= 8) remote_low <= 1'b0;
  end

  always @(posedge clk) if (sda_oe) oe_cycles <= oe_cycles + 1;

  initial begin
    #2_000_000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic arm_remote(input logic [7:0] b);
    remote_byte = b;
    remote_idx = 0;
    remote_low = 1'b0;
    rises = 0;
    oe_cycles = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 scl", scl_out, 1'b1);
    check("R1 oe", sda_oe, 1'b0);
    check("R1 irq", irq, 1'b0);
    reg_read(2'd0, v); check("R1 shift", v, 8'h00);
    reg_read(2'd1, v); check("R1 cmp", v, 8'h00);
    reg_read(2'd2, v); check("R1 status", v, 8'h04);
  endtask

  task automatic t_enable_late();
    logic [7:0] v;
    arm_remote(8'hFF);
    reg_write(2'd0, 8'h5A);
    reg_write(2'd2, 8'h01);
    repeat (150) @(negedge clk);
    check("R2 no clock edges", rises, 0);
    check("R2 no irq", irq, 1'b0);
    reg_read(2'd0, v); check("R2 shift holds", v, 8'h5A);
  endtask

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] cmp,
                          input logic [7:0] rem);
    reg_write(2'd2, 8'h01);
    reg_write(2'd1, cmp);
    arm_remote(rem);
    reg_write(2'd0, tx);
    wait_irq();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_transmit();
    logic [7:0] v;
    run_xfer(8'hA5, 8'hA5, 8'hFF);
    check("R3 edge count", rises, 8);
    check("R3 spacing", last_rise - first_rise, 7 * 2 * HALF * 10);
    check("R3 irq", irq, 1'b1);
    check("R3 clock idle high", scl_out, 1'b1);
    check("R4 line MSB first", obs_line, 8'hA5);
    reg_read(2'd0, v); check("R5 readback", v, 8'hA5);
    reg_read(2'd2, v); check("R7 match set", v[2], 1'b1);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    run_xfer(8'hF0, 8'hF0, 8'h3C);
    check("R5 wired line", obs_line, 8'h30);
    reg_read(2'd0, v); check("R5 collided readback", v, 8'h30);
    reg_read(2'd2, v); check("R7 match cleared", v[2], 1'b0);
    reg_write(2'd1, 8'h30);
    reg_read(2'd2, v); check("R7 match after cmp load", v[2], 1'b1);
  endtask

  task automatic t_receive();
    logic [7:0] v;
    run_xfer(8'hFF, 8'h00, 8'h96);
    check("R6 never pulled", oe_cycles, 0);
    reg_read(2'd0, v); check("R6 received", v, 8'h96);
    check("R6 edge count", rises, 8);
  endtask

  task automatic t_write_ignored();
    logic [7:0] v;
    reg_write(2'd2, 8'h01);
    arm_remote(8'hFF);
    reg_write(2'd0, 8'h81);
    wait (rises == 4);
    reg_write(2'd0, 8'h00);
    wait_irq();
    repeat (4) @(negedge clk);
    check("R8 edges", rises, 8);
    reg_read(2'd0, v); check("R8 result", v, 8'h81);
    check("R8 line", obs_line, 8'h81);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    check("R9 set", irq, 1'b1);
    reg_write(2'd2, 8'h03);
    check("R9 kept by bit1=1", irq, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 still set", irq, 1'b1);
    reg_write(2'd2, 8'h01);
    check("R9 cleared", irq, 1'b0);
    reg_read(2'd2, v); check("R9 enable kept", v[0], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_late();
    t_transmit();
    t_collision();
    t_receive();
    t_write_ignored();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule